// File: doc/BRIEF.md
# Rollover-Aligned Serial Transmitter

This block turns a byte into an asynchronous serial frame on one output line: a low start bit, the data bits with the least significant bit first, and a high stop bit. The bit clock is a free-running divide-by-OVS prescaler that advances once per `baud_tick` pulse, where `baud_tick` runs at OVS times the bit rate. Every bit boundary on the line falls on a wrap of that prescaler, never on the write.

A single-cycle `wr_en` with a byte on `wr_data` queues a frame. The frame waits for the next prescaler wrap and then starts. The byte is held in a shift register one bit wider than the data, with a marker 1 placed above the MSB. The end of the frame is found when that marker reaches the bit just above the output position. When the frame ends, `tx_done` goes high and stays high until `done_clr` is pulsed. A write is only taken while no frame is queued or in flight.

Top module: `uart_rollover_tx`

## Requirements
- R1: During and after reset, `tx_line` is 1 and `tx_done` is 0.
- R2: A frame on `tx_line` is a start bit of 0, then the DATA_W bits of the written byte with bit 0 first, then a stop bit of 1. Each bit lasts exactly one prescaler wrap period (OVS ticks), and `tx_line` changes only on the clock edge of a wrap.
- R3: The start bit appears on the first prescaler wrap after the clock edge that takes the write. A wrap in the same cycle as the write does not count. Until that wrap, `tx_line` stays 1.
- R4: `tx_done` rises on the wrap that is DATA_W+2 wraps after the write (the 10th for 8-bit data). That is the same edge on which `tx_line` returns to 1. It is not high at the wrap before.
- R5: A write that arrives while a frame is queued or being sent is ignored. The frame in flight keeps its original byte, and no second frame follows it.
- R6: `tx_done` holds at 1 until a `done_clr` pulse, and it reads 0 on the cycle after the pulse. A new write does not clear it.
- R7: The prescaler advances only in cycles where `baud_tick` is 1. With ticks spaced apart or stopped, the bit times stretch to match, and a queued frame waits while no ticks arrive.
- R8: Whenever no frame is being sent, `tx_line` is 1. A write taken right after `tx_done` rises starts a new frame at the next wrap, so the stop bit lasts exactly one bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Oversampling tick at OVS times the bit rate |
| wr_en | input | 1 | Single-cycle write strobe that queues a frame |
| wr_data | input | DATA_W | Byte to send, sampled with `wr_en` |
| done_clr | input | 1 | Clears the done flag |
| tx_line | output | 1 | Serial output, idle high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
The bench builds the block with OVS=4 and DATA_W=8, so a full frame is only 40 ticks long. This makes it cheap to cover many alignments between the write and the prescaler phase, including a write that lands exactly on a wrap cycle. Tick spacing is varied at run time: one tick per clock, one tick every third clock, and a stretch with no ticks while a frame is queued. Together these show that bit timing follows the prescaler and not the clock. Late writes are placed both in the queued window and in the middle of the data bits, to show that neither disturbs the frame or queues another.

// File: rtl/uart_rtx_pkg.sv
`timescale 1ns/1ps
package uart_rtx_pkg;

  // Frame controller phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // nothing queued, line idles high
    PH_PEND  = 2'd1,  // byte loaded, waiting for a prescaler wrap
    PH_START = 2'd2,  // start bit on the line
    PH_DATA  = 2'd3   // data bits shifting out
  } tx_phase_e;

  function automatic logic phase_is_sending(tx_phase_e p);
    return (p == PH_START) || (p == PH_DATA);
  endfunction

endpackage

// File: rtl/uart_rtx_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release of the active-low reset.
module uart_rtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/uart_rtx_prescale.sv
`timescale 1ns/1ps
// Free-running divide-by-OVS counter advanced by the oversampling tick.
// roll is high in the tick cycle that wraps the counter.
module uart_rtx_prescale #(
  parameter  int OVS   = 16,
  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             roll
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OVS - 1);
  localparam bit               IS_POW2 = ((OVS & (OVS - 1)) == 0);

  logic             at_top;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign at_top  = (cnt_q == CNT_TOP);
  assign roll    = tick && at_top;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign cnt_en  = tick;

  generate
    if (IS_POW2) begin : g_natural_wrap
      // Counter width matches the period, overflow wraps on its own
      assign cnt_d = cnt_inc;
    end else begin : g_compare_wrap
      assign cnt_d = at_top ? '0 : cnt_inc;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/uart_rtx_shreg.sv
`timescale 1ns/1ps
// Transmit shift register with a marker bit above the data.
// Shifts toward bit 0 with zeros entering at the top.
module uart_rtx_shreg #(
  parameter  int DATA_W = 8,
  localparam int SR_W   = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] load_data,
  output logic [SR_W-1:0]   sr_q,
  output logic              out_nxt,
  output logic              last_bit
);

  logic [SR_W-1:0] sr_d;
  logic            sr_en;

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      sr_d = {1'b1, load_data};
    end else if (shift) begin
      sr_d = {1'b0, sr_q[SR_W-1:1]};
    end
  end

  assign sr_en   = load | shift;
  assign out_nxt = sr_d[0];

  // Marker sits directly above the output bit with only zeros above it:
  // the MSB is on the line and one final shift remains.
  assign last_bit = sr_q[1] && (sr_q[SR_W-1:2] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

endmodule

// File: rtl/uart_rtx_ctrl.sv
`timescale 1ns/1ps
// Frame sequencing: queue on write, start on wrap, shift per wrap, finish on marker.
module uart_rtx_ctrl
  import uart_rtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      roll,
  input  logic      wr_en,
  input  logic      done_clr,
  input  logic      last_bit,
  output tx_phase_e phase_q,
  output tx_phase_e phase_d,
  output logic      load,
  output logic      shift,
  output logic      done_q
);

  logic done_set;
  logic done_d;
  logic done_en;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    shift    = 1'b0;
    done_set = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (wr_en) begin
          load    = 1'b1;
          phase_d = PH_PEND;
        end
      end
      PH_PEND: begin
        if (roll) begin
          phase_d = PH_START;
        end
      end
      PH_START: begin
        if (roll) begin
          phase_d = PH_DATA;
        end
      end
      PH_DATA: begin
        if (roll) begin
          shift = 1'b1;
          if (last_bit) begin
            phase_d  = PH_IDLE;
            done_set = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Setting the flag wins over a clear in the same cycle
  always_comb begin
    done_en = done_set | done_clr;
    done_d  = done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/uart_rollover_tx.sv
`timescale 1ns/1ps
module uart_rollover_tx
  import uart_rtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_clr,
  output logic              tx_line,
  output logic              tx_done
);

  localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int SR_W  = DATA_W + 1;

  logic             rst_q_n;
  logic [CNT_W-1:0] cnt_q;
  logic             roll;
  tx_phase_e        phase_q;
  tx_phase_e        phase_d;
  logic             load;
  logic             shift;
  logic [SR_W-1:0]  sr_q;
  logic             out_nxt;
  logic             last_bit;
  logic             line_d;

  uart_rtx_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  uart_rtx_prescale #(.OVS(OVS)) u_pre (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tick  (baud_tick),
    .cnt_q (cnt_q),
    .roll  (roll)
  );

  uart_rtx_shreg #(.DATA_W(DATA_W)) u_sr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load      (load),
    .shift     (shift),
    .load_data (wr_data),
    .sr_q      (sr_q),
    .out_nxt   (out_nxt),
    .last_bit  (last_bit)
  );

  uart_rtx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .roll     (roll),
    .wr_en    (wr_en),
    .done_clr (done_clr),
    .last_bit (last_bit),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .load     (load),
    .shift    (shift),
    .done_q   (tx_done)
  );

  // Registered line driver, fed from next-state values so that the
  // line moves on the same edge as the phase.
  always_comb begin
    case (phase_d)
      PH_START: line_d = 1'b0;
      PH_DATA:  line_d = out_nxt;
      default:  line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tx_line <= 1'b1;
    end else begin
      tx_line <= line_d;
    end
  end

endmodule

// File: rtl/uart_rtx_checker.sv
`timescale 1ns/1ps
module uart_rtx_checker
  import uart_rtx_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int OVS    = 16,
  localparam int CNT_W  = (OVS > 1) ? $clog2(OVS) : 1,
  localparam int SR_W   = DATA_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             roll,
  input logic             done_clr,
  input logic             tx_line,
  input logic             tx_done,
  input tx_phase_e        phase,
  input logic [CNT_W-1:0] cnt,
  input logic [SR_W-1:0]  sr
);

  AST_LINE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(roll) |-> $stable(tx_line)); // R2

  AST_START_AFTER_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_is_sending(phase)) |-> ($past(roll) && ($past(phase) == PH_PEND))); // R3

  AST_DONE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> ($past(roll) && ($past(phase) == PH_DATA) && (phase == PH_IDLE))); // R4

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(phase) != PH_IDLE) && !$past(roll)) |-> $stable(sr)); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_done) && !$past(done_clr)) |-> tx_done); // R6

  AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt)); // R7

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) && ($past(phase) == PH_IDLE)) |-> tx_line); // R8

endmodule

bind uart_rollover_tx uart_rtx_checker #(.DATA_W(DATA_W), .OVS(OVS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .tick     (baud_tick),
  .roll     (roll),
  .done_clr (done_clr),
  .tx_line  (tx_line),
  .tx_done  (tx_done),
  .phase    (phase_q),
  .cnt      (cnt_q),
  .sr       (sr_q)
);

// File: tb/tb_uart_rollover_tx.sv
`timescale 1ns/1ps
module tb_uart_rollover_tx;

  localparam int DW  = 8;
  localparam int OVS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          baud_tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          done_clr = 1'b0;
  logic          tx_line;
  logic          tx_done;

  int checks = 0;
  int errors = 0;
  bit tick_en = 1'b0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  int gap = 1;
  int gcnt = 0;

  always #2.5 clk = ~clk;

  uart_rollover_tx #(.DATA_W(DW), .OVS(OVS)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .done_clr  (done_clr),
    .tx_line   (tx_line),
    .tx_done   (tx_done)
  );

  // Tick source: one pulse every 'gap' clocks while enabled
  always @(posedge clk) begin
    if (!tick_en) begin
      baud_tick <= 1'b0;
      gcnt      <= 0;
    end else begin
      baud_tick <= (gcnt == 0);
      gcnt      <= (gcnt + 1 >= gap) ? 0 : gcnt + 1;
    end
  end

  // Reference model written from the requirements (bit index per wrap)
  int            ref_cnt;
  int            ref_bit;
  logic          ref_pend;
  logic          ref_done;
  logic [DW-1:0] ref_data;
  logic          ref_roll;
  logic          exp_line;

  assign ref_roll = baud_tick && (ref_cnt == OVS - 1);
  assign exp_line = (ref_bit == 1) ? 1'b0 :
                    ((ref_bit >= 2) ? ref_data[ref_bit-2] : 1'b1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= 0;
      ref_bit  <= 0;
      ref_pend <= 1'b0;
      ref_done <= 1'b0;
      ref_data <= '0;
    end else begin
      if (baud_tick) ref_cnt <= (ref_cnt == OVS - 1) ? 0 : ref_cnt + 1;
      if (done_clr) ref_done <= 1'b0;
      if (ref_roll) begin
        if (ref_pend) begin
          ref_pend <= 1'b0;
          ref_bit  <= 1;
        end else if (ref_bit == DW + 1) begin
          ref_bit  <= 0;
          ref_done <= 1'b1;
        end else if (ref_bit != 0) begin
          ref_bit <= ref_bit + 1;
        end
      end
      if (wr_en && !ref_pend && (ref_bit == 0)) begin
        ref_pend <= 1'b1;
        ref_data <= wr_data;
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && mon_en && !finished) begin
      checks++;
      if (tx_line !== exp_line) begin
        errors++;
        $display("FAIL R2 line vs model: got %b expected %b at %0t", tx_line, exp_line, $time);
      end
      checks++;
      if (tx_done !== ref_done) begin
        errors++;
        $display("FAIL R4 done vs model: got %b expected %b at %0t", tx_done, ref_done, $time);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // Advance past the next wrap edge; any one-cycle write is dropped on the way
  task automatic wait_roll();
    while (!ref_roll) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  // Sample the line after each of the DW+2 wraps following a write
  task automatic capture(input int inj_k, input logic [DW-1:0] inj_b,
                         output logic [DW+1:0] s, output logic dn_before);
    dn_before = 1'b0;
    for (int k = 0; k < DW + 2; k++) begin
      if (k == inj_k) begin
        wr_en   = 1'b1;
        wr_data = inj_b;
      end
      wait_roll();
      s[k] = tx_line;
      if (k == DW) dn_before = tx_done;
    end
  endtask

  task automatic judge(input string name, input logic [DW+1:0] s, input logic [DW-1:0] b,
                       input logic dn_before, input logic exp_before);
    check({name, " R3 start bit on first wrap"}, s[0], 1'b0);
    check({name, " R2 data LSB first"}, s[DW:1], b);
    check({name, " R2 stop bit"}, s[DW+1], 1'b1);
    check({name, " R4 done state one wrap early"}, dn_before, exp_before);
    check({name, " R4 done at final wrap"}, tx_done, 1'b1);
  endtask

  task automatic t_frame(input string name, input logic [DW-1:0] b, input bit align,
                         input int inj_k, input logic [DW-1:0] inj_b, input bit keep_done);
    logic [DW+1:0] s;
    logic          dn;
    if (!keep_done) pulse_clear();
    @(negedge clk);
    if (align) while (!ref_roll) @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    check({name, " R3 line high while queued"}, tx_line, 1'b1);
    if (keep_done) check({name, " R6 write leaves done set"}, tx_done, 1'b1);
    capture(inj_k, inj_b, s, dn);
    judge(name, s, b, dn, keep_done);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 line during reset", tx_line, 1'b1);
    check("R1 done during reset", tx_done, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 line after reset", tx_line, 1'b1);
    check("R1 done after reset", tx_done, 1'b0);
  endtask

  task automatic t_done_hold();
    repeat (3 * OVS + 5) @(negedge clk);
    check("R6 done held", tx_done, 1'b1);
    pulse_clear();
    check("R6 done cleared", tx_done, 1'b0);
  endtask

  task automatic t_no_second_frame();
    for (int k = 0; k < 3; k++) begin
      wait_roll();
      check("R5 no frame from ignored write", tx_line, 1'b1);
    end
    check("R8 idle line high", tx_line, 1'b1);
  endtask

  task automatic t_stalled_ticks();
    logic [DW+1:0] s;
    logic          dn;
    pulse_clear();
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 8'h81;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (50) @(negedge clk);
    check("R7 queued frame waits without ticks", tx_line, 1'b1);
    check("R7 no done without ticks", tx_done, 1'b0);
    tick_en = 1'b1;
    capture(-1, '0, s, dn);
    judge("stall R7", s, 8'h81, dn, 1'b0);
  endtask

  initial begin
    t_reset();
    mon_en  = 1'b1;
    tick_en = 1'b1;
    repeat (3) @(negedge clk);

    t_frame("basic", 8'hA5, 1'b0, -1, '0, 1'b0);
    t_done_hold();
    t_frame("aligned zeros", 8'h00, 1'b1, -1, '0, 1'b0);
    t_frame("aligned ones", 8'hFF, 1'b1, -1, '0, 1'b0);
    t_frame("R5 write while queued", 8'h3C, 1'b0, 0, 8'hFF, 1'b0);
    t_no_second_frame();
    t_frame("R5 write mid data", 8'h96, 1'b0, 4, 8'h69, 1'b0);
    t_no_second_frame();
    t_frame("R8 back to back", 8'h5A, 1'b0, -1, '0, 1'b1);
    t_frame("R8 second back to back", 8'h17, 1'b0, -1, '0, 1'b1);
    gap = 3;
    t_frame("R7 spaced ticks", 8'hC9, 1'b0, -1, '0, 1'b0);
    t_frame("R7 spaced aligned", 8'h42, 1'b1, -1, '0, 1'b0);
    gap = 1;
    t_stalled_ticks();

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule